// File: doc/BRIEF.md
# Cycle-by-cycle current limit supervisor

This block is the synchronous protection and handshake logic for a dual-channel low-side gate driver. Both channels share one current-sense input. Each clock it takes two PWM inputs and the digitised millivolt samples of the sense current, the limit setting, the main supply and the regulated rail. It drives two gate-enable outputs and one current-limit flag back to the host controller.

An overcurrent trip occurs when the sense sample plus a fixed 25 mV offset exceeds the effective limit. A trip blanks both gates and raises the flag. Both stay latched until a PWM rising edge arrives in a cycle with no trip. At start-up the flag stays high until both supply detectors report good. The host therefore waits for the flag to fall before it sends power pulses. If the flag stays up, the host polls the block with a short PWM pulse.

Top module: `cl_supervisor`

## Requirements
- R1: A trip occurs when sense_mv_i + 25 > the effective limit, compared strictly. The cycle after a trip sample, gate_o is 2'b00 and flag_o is 1. With sense + 25 equal to the limit, there is no trip.
- R2: After a trip, gate_o stays 0 and flag_o stays 1 until a rising edge on either PWM bit (0 in the previous sample, 1 now). That edge must fall in a cycle without a trip. In that cycle the fault clears and the gates follow the PWM inputs.
- R3: When a trip and a PWM rising edge are sampled in the same cycle, the trip wins and the fault stays latched.
- R4: With no fault and both supplies good, gate_o[c] equals pwm_i[c] sampled one clock earlier, independently per channel, and flag_o is 0.
- R5: A nonzero limit code below 250 is raised to 250. A code above 1000 is lowered to 1000. A code from 250 to 1000 is used unchanged.
- R6: When limit_open_i is 1, the effective limit is 500 whatever limit_mv_i holds.
- R7: A limit code of 0 with limit_open_i at 0 is used unclamped. A sense of 0 then trips, and the fault stays latched across PWM pulses while that condition lasts.
- R8: The main supply detector becomes good at vdd_mv_i >= 4500. Once good, it drops only when vdd_mv_i < 4250.
- R9: The rail detector becomes good at rail_mv_i >= 3000. Once good, it drops only when rail_mv_i < 2800.
- R10: During reset, gate_o is 0 and flag_o is 1. While either supply is not good, gate_o is 0 and flag_o is 1. The flag falls in the cycle after both become good, provided there is no fault.
- R11: A trip seen while the supplies come up stays latched after they become good. Only a PWM rising edge with no trip clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | N_CH | PWM command per channel |
| sense_mv_i | input | MV_W | Shared sense sample, mV |
| limit_mv_i | input | MV_W | Commanded limit, mV |
| limit_open_i | input | 1 | Limit input is floating; use the default |
| vdd_mv_i | input | MV_W | Main supply sample, mV |
| rail_mv_i | input | MV_W | Regulated rail sample, mV |
| gate_o | output | N_CH | Gate enable per channel |
| flag_o | output | 1 | Current-limit / not-ready flag to the host |

## Verification
A stuck or lost fault latch shows up at the ports one clock after the next sample. Either a gate follows PWM while the flag reads 1, or the flag falls with no rising edge. A wrong hysteresis state shows up as gates that drop or return at the wrong supply level, one cycle after that sample. A mis-clamped threshold moves the trip point, so sense values one millivolt either side of each clamp boundary expose it on the very next clock.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int MV_W = 14;
  typedef logic [MV_W-1:0] mv_t;
endpackage

// File: rtl/cls_hyst.sv
module cls_hyst
  import cls_pkg::*;
#(
  parameter int ON_MV  = 4500,
  parameter int OFF_MV = 4250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  mv_t  level_i,
  output logic ok_d_o,
  output logic ok_q_o
);
  always_comb begin
    if (ok_q_o) ok_d_o = (level_i >= mv_t'(OFF_MV));
    else        ok_d_o = (level_i >= mv_t'(ON_MV));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q_o <= 1'b0;
    else         ok_q_o <= ok_d_o;
  end
endmodule

// File: rtl/cls_limit.sv
module cls_limit
  import cls_pkg::*;
#(
  parameter int OFFSET_MV = 25,
  parameter int MIN_MV    = 250,
  parameter int MAX_MV    = 1000,
  parameter int DEF_MV    = 500
) (
  input  mv_t  sense_i,
  input  mv_t  limit_i,
  input  logic open_i,
  output logic trip_o
);
  localparam int W = MV_W + 1;

  logic [W-1:0] lim_eff, lim_ext, lhs;

  assign lim_ext = {1'b0, limit_i};

  always_comb begin
    if (open_i)                   lim_eff = W'(DEF_MV);
    else if (limit_i == '0)       lim_eff = '0;  // zero-current command passes unclamped
    else if (lim_ext < W'(MIN_MV)) lim_eff = W'(MIN_MV);
    else if (lim_ext > W'(MAX_MV)) lim_eff = W'(MAX_MV);
    else                          lim_eff = lim_ext;
  end

  assign lhs    = {1'b0, sense_i} + W'(OFFSET_MV);
  assign trip_o = lhs > lim_eff;
endmodule

// File: rtl/cls_edge.sv
module cls_edge #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pwm_i,
  output logic [N_CH-1:0] rise_o
);
  logic [N_CH-1:0] prev_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[c] <= 1'b0;
      else         prev_q[c] <= pwm_i[c];
    end
    assign rise_o[c] = pwm_i[c] & ~prev_q[c];
  end
endmodule

// File: rtl/cl_supervisor.sv
module cl_supervisor
  import cls_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int OFFSET_MV   = 25,
  parameter int LIM_MIN_MV  = 250,
  parameter int LIM_MAX_MV  = 1000,
  parameter int LIM_DEF_MV  = 500,
  parameter int VDD_ON_MV   = 4500,
  parameter int VDD_OFF_MV  = 4250,
  parameter int RAIL_ON_MV  = 3000,
  parameter int RAIL_OFF_MV = 2800
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pwm_i,
  input  logic [MV_W-1:0] sense_mv_i,
  input  logic [MV_W-1:0] limit_mv_i,
  input  logic            limit_open_i,
  input  logic [MV_W-1:0] vdd_mv_i,
  input  logic [MV_W-1:0] rail_mv_i,
  output logic [N_CH-1:0] gate_o,
  output logic            flag_o
);
  logic            vdd_ok_d, vdd_ok_q, rail_ok_d, rail_ok_q, sup_ok;
  logic            trip, any_rise, fault_q, fault_d;
  logic [N_CH-1:0] rise;

  cls_hyst #(.ON_MV(VDD_ON_MV), .OFF_MV(VDD_OFF_MV)) i_vdd_det (
    .clk_i, .rst_ni, .level_i(vdd_mv_i), .ok_d_o(vdd_ok_d), .ok_q_o(vdd_ok_q)
  );

  cls_hyst #(.ON_MV(RAIL_ON_MV), .OFF_MV(RAIL_OFF_MV)) i_rail_det (
    .clk_i, .rst_ni, .level_i(rail_mv_i), .ok_d_o(rail_ok_d), .ok_q_o(rail_ok_q)
  );

  cls_limit #(
    .OFFSET_MV(OFFSET_MV), .MIN_MV(LIM_MIN_MV), .MAX_MV(LIM_MAX_MV), .DEF_MV(LIM_DEF_MV)
  ) i_limit (
    .sense_i(sense_mv_i), .limit_i(limit_mv_i), .open_i(limit_open_i), .trip_o(trip)
  );

  cls_edge #(.N_CH(N_CH)) i_edge (
    .clk_i, .rst_ni, .pwm_i, .rise_o(rise)
  );

  assign sup_ok   = vdd_ok_d & rail_ok_d;
  assign any_rise = |rise;
  // trip outranks a same-cycle rising edge
  assign fault_d  = trip | (fault_q & ~any_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      gate_o  <= '0;
      flag_o  <= 1'b1;
    end else begin
      fault_q <= fault_d;
      gate_o  <= (sup_ok && !fault_d) ? pwm_i : '0;
      flag_o  <= ~sup_ok | fault_d;
    end
  end

  logic unused_q;
  assign unused_q = vdd_ok_q ^ rail_ok_q;
endmodule

// File: rtl/cl_supervisor_chk.sv
module cl_supervisor_chk #(
  parameter int N_CH = 2,
  parameter int VDD_OFF_MV = 4250
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] pwm_i,
  input logic [N_CH-1:0] gate_o,
  input logic            flag_o,
  input logic            trip,
  input logic            any_rise,
  input logic            fault_q,
  input logic            sup_ok,
  input logic            vdd_ok_q,
  input logic [13:0]     vdd_mv_i
);
  a_r1_trip_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> (gate_o == '0) && flag_o);

  a_r2_fault_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !any_rise) |=> (gate_o == '0) && flag_o);

  a_r3_trip_beats_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip && any_rise) |=> fault_q);

  a_r4_gate_needs_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o & ~$past(pwm_i)) == '0);

  a_r8_vdd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vdd_ok_q && vdd_mv_i >= 14'(VDD_OFF_MV)) |=> vdd_ok_q);

  a_r10_no_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_ok |=> (gate_o == '0) && flag_o);
endmodule

bind cl_supervisor cl_supervisor_chk #(.N_CH(N_CH), .VDD_OFF_MV(VDD_OFF_MV)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .gate_o(gate_o), .flag_o(flag_o),
  .trip(trip), .any_rise(any_rise), .fault_q(fault_q), .sup_ok(sup_ok),
  .vdd_ok_q(vdd_ok_q), .vdd_mv_i(vdd_mv_i)
);

// File: tb/test_cl_supervisor.sv
module test_cl_supervisor;
  typedef struct packed {
    logic [1:0]  pwm;
    logic [13:0] sense;
    logic [13:0] lim;
    logic        open;
    logic [13:0] vdd;
    logic [13:0] rail;
    logic [1:0]  egate;
    logic        eflag;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b0}, // R4
    '{2'b01, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b01, 1'b0}, // R4
    '{2'b10, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b10, 1'b0}, // R4
    '{2'b11, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b11, 1'b0}, // R4
    '{2'b11, 14'd780, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R1
    '{2'b11, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R2
    '{2'b00, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R2
    '{2'b01, 14'd100, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b01, 1'b0}, // R2
    '{2'b01, 14'd775, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b01, 1'b0}, // R1 boundary
    '{2'b00, 14'd776, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R1
    '{2'b10, 14'd800, 14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R3
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd3300, 2'b11, 1'b0}, // R2
    '{2'b11, 14'd990, 14'd3000, 1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R5
    '{2'b00, 14'd0,   14'd3000, 1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R5
    '{2'b01, 14'd974, 14'd3000, 1'b0, 14'd5000, 14'd3300, 2'b01, 1'b0}, // R5
    '{2'b01, 14'd230, 14'd100,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R5
    '{2'b00, 14'd0,   14'd100,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R5
    '{2'b10, 14'd224, 14'd100,  1'b0, 14'd5000, 14'd3300, 2'b10, 1'b0}, // R5
    '{2'b10, 14'd480, 14'd900,  1'b1, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R6
    '{2'b00, 14'd0,   14'd900,  1'b1, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R6
    '{2'b01, 14'd474, 14'd900,  1'b1, 14'd5000, 14'd3300, 2'b01, 1'b0}, // R6
    '{2'b01, 14'd0,   14'd0,    1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R7
    '{2'b00, 14'd0,   14'd0,    1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R7
    '{2'b01, 14'd0,   14'd0,    1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R7
    '{2'b00, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd3300, 2'b00, 1'b1}, // R7
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd3300, 2'b11, 1'b0}, // R2
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd4400, 14'd3300, 2'b11, 1'b0}, // R8
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd4249, 14'd3300, 2'b00, 1'b1}, // R8
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd4400, 14'd3300, 2'b00, 1'b1}, // R8
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd4500, 14'd3300, 2'b11, 1'b0}, // R8
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd2900, 2'b11, 1'b0}, // R9
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd2799, 2'b00, 1'b1}, // R9
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd2999, 2'b00, 1'b1}, // R9
    '{2'b11, 14'd0,   14'd800,  1'b0, 14'd5000, 14'd3000, 2'b11, 1'b0}  // R9
  };
  localparam string TAG [NV] = '{
    "R4","R4","R4","R4","R1","R2","R2","R2","R1","R1","R3","R2",
    "R5","R5","R5","R5","R5","R5","R6","R6","R6","R7","R7","R7",
    "R7","R2","R8","R8","R8","R8","R9","R9","R9","R9"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pwm = '0;
  logic [13:0] sense = '0, lim = 14'd800, vdd = '0, rail = '0;
  logic        open_l = 1'b0;
  logic [1:0]  gate;
  logic        flag;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cl_supervisor i_cl_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .sense_mv_i(sense), .limit_mv_i(lim),
    .limit_open_i(open_l), .vdd_mv_i(vdd), .rail_mv_i(rail), .gate_o(gate), .flag_o(flag)
  );

  task automatic check(input string tag, input logic [1:0] eg, input logic ef);
    n_chk++;
    if (gate !== eg || flag !== ef) begin
      n_fail++;
      $display("FAIL %s: gate=%b flag=%b expected gate=%b flag=%b", tag, gate, flag, eg, ef);
    end
  endtask

  task automatic step(input logic [1:0] p, input logic [13:0] s, input logic [13:0] l,
                      input logic o, input logic [13:0] v, input logic [13:0] r);
    pwm = p; sense = s; lim = l; open_l = o; vdd = v; rail = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R10 reset", 2'b00, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].pwm, TBL[i].sense, TBL[i].lim, TBL[i].open, TBL[i].vdd, TBL[i].rail);
      check(TAG[i], TBL[i].egate, TBL[i].eflag);
    end

    // R11: trip while supplies are down stays latched after they come up
    pwm = 2'b00; sense = 14'd800; lim = 14'd800; open_l = 1'b0; vdd = '0; rail = '0;
    do_reset();
    check("R10 reset again", 2'b00, 1'b1);
    rst_n = 1'b1;
    step(2'b00, 14'd800, 14'd800, 1'b0, 14'd0, 14'd0);
    check("R10 supplies down", 2'b00, 1'b1);
    step(2'b00, 14'd800, 14'd800, 1'b0, 14'd5000, 14'd3300);
    check("R11 trip at power-up", 2'b00, 1'b1);
    step(2'b00, 14'd0, 14'd800, 1'b0, 14'd5000, 14'd3300);
    check("R11 still latched", 2'b00, 1'b1);
    step(2'b01, 14'd0, 14'd800, 1'b0, 14'd5000, 14'd3300);
    check("R11 poll pulse clears", 2'b01, 1'b0);

    // R10: clean power-up, flag falls the cycle after both supplies are good
    pwm = 2'b00; sense = '0; vdd = '0; rail = '0;
    do_reset();
    rst_n = 1'b1;
    step(2'b00, 14'd0, 14'd800, 1'b0, 14'd5000, 14'd0);
    check("R10 rail missing", 2'b00, 1'b1);
    step(2'b00, 14'd0, 14'd800, 1'b0, 14'd5000, 14'd3300);
    check("R10 ready", 2'b00, 1'b0);
    step(2'b10, 14'd0, 14'd800, 1'b0, 14'd5000, 14'd3300);
    check("R4 after ready", 2'b10, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule